// File: doc/BRIEF.md
# Lane Link Synchronizer for a Serial Converter Receiver

This block is the receive link-layer controller for one serial converter lane. Each clock it may take one 32-bit lane word of four octets. Octet 0 sits in bits [7:0] and is the earliest in time; octet n sits in bits [8n+7:8n]. Every octet comes with a control-character flag, a code error flag and a disparity error flag. The block holds the active-low sync request until the lane shows a clean run of comma characters (0xBC, flagged as control). It then follows the initial lane alignment sequence octet by octet, keeps the link parameters sent in its second multiframe, and declares the lane aligned when user data starts.

The state machine has four states. S_CGS holds sync low and counts comma words. S_SYNCED has sync released and waits for the alignment sequence. S_ILAS checks the four alignment multiframes. S_DATA passes user words on. Its transitions are:
- T_CGS_DONE (S_CGS to S_SYNCED): enough consecutive clean comma words have arrived.
- T_ILAS_START (S_SYNCED to S_ILAS): the first non-comma word is a legal opening word.
- T_ILAS_ABORT (S_SYNCED or S_ILAS to S_CGS, with an interrupt): an illegal word arrives.
- T_ALIGNED (S_ILAS to S_DATA): the final word of the fourth multiframe is legal.

The only way out of S_DATA is reset. A multiframe is FRAME_OCTETS*MF_FRAMES octets and must be a multiple of four and at least 20. This keeps every multiframe start on octet 0 of a word.

Top module: `jrx_lane_sync`

## Requirements
- R1: After reset, sync_n is 0, lane_aligned is 0, link_irq is 0 and all four cfg_word outputs are 0.
- R2: sync_n goes to 1 only after a whole valid word has all four octets equal to 0xBC with their control flags set and no error flags. Any other word seen in S_CGS restarts the count, and a word with only some comma octets does not release sync.
- R3: In S_CGS, a valid word with any code or disparity error flag gives link_irq high for one cycle on the next clock. sync_n stays 0.
- R4: In S_SYNCED, clean comma words keep sync_n at 1. The first non-comma word must open the alignment sequence. If it does not, sync_n returns to 0 and link_irq pulses on the next clock.
- R5: Each alignment word must follow these rules. Octet 0 of the first word of every multiframe is control 0x1C. Octet 1 of that word in the second multiframe is control 0x9C. Octet 3 of the last word of every multiframe is control 0x7C. Every other octet has its control flag clear, and no octet carries an error flag. Any breach returns the block to S_CGS (sync_n 0) with a link_irq pulse on the next clock.
- R6: The 14 octets that follow 0x9C in the second multiframe are kept. Configuration octet j goes to cfg_word[j/4], bits [8*(j%4)+7 : 8*(j%4)], and the top two bytes of cfg_word3 stay 0.
- R7: lane_aligned goes high on the clock that takes the final legal word of the fourth multiframe, and not earlier. The next valid word is the first user word.
- R8: In S_DATA, somf is 4'b0001 on the first valid word of each multiframe, which is every (FRAME_OCTETS*MF_FRAMES/4)-th valid word counting from the first user word. Otherwise somf is 0.
- R9: In S_DATA, an error flag on a valid word pulses link_irq on the next clock and lane_aligned stays 1.
- R10: A cycle with lane_valid low changes no state: sync_n, lane_aligned and cfg_word hold, link_irq is 0 on the next clock, and user_valid is 0.
- R11: In S_DATA, user_valid follows lane_valid, and user_data equals lane_data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_valid | input | 1 | Lane word present this cycle |
| lane_data | input | 32 | Four decoded octets, octet 0 in bits [7:0] |
| lane_ctl | input | 4 | Per-octet control-character flag |
| lane_cerr | input | 4 | Per-octet code error flag |
| lane_derr | input | 4 | Per-octet disparity error flag |
| sync_n | output | 1 | Active-low synchronization request |
| lane_aligned | output | 1 | Alignment sequence complete, user data flowing |
| somf | output | 4 | Start-of-multiframe marker, one bit per octet position |
| link_irq | output | 1 | One-cycle error interrupt pulse |
| user_valid | output | 1 | User word valid |
| user_data | output | 32 | User word |
| cfg_word0 | output | 32 | Configuration octets 0 to 3 |
| cfg_word1 | output | 32 | Configuration octets 4 to 7 |
| cfg_word2 | output | 32 | Configuration octets 8 to 11 |
| cfg_word3 | output | 32 | Configuration octets 12 and 13 in the low half |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is alignment completion and error detection. The bench puts a disparity error on the final 0x7C word, and by random choice on other alignment words. It expects the abort to win: lane_aligned stays 0, sync_n drops and link_irq pulses.

The second pair is the multiframe marker and the data-phase interrupt. The bench places an errored word exactly on a multiframe start in S_DATA. It expects somf at 4'b0001 before the edge, and link_irq plus lane_aligned both high after it.

// File: rtl/jrx_pkg.sv
package jrx_pkg;

    typedef enum logic [1:0] {
        S_CGS    = 2'd0,
        S_SYNCED = 2'd1,
        S_ILAS   = 2'd2,
        S_DATA   = 2'd3
    } lsync_state_t;

    localparam logic [7:0] CH_COMMA = 8'hBC;
    localparam logic [7:0] CH_MFBEG = 8'h1C;
    localparam logic [7:0] CH_CFGMK = 8'h9C;
    localparam logic [7:0] CH_MFEND = 8'h7C;

endpackage

// File: rtl/jrx_ilas_pos.sv
module jrx_ilas_pos #(
    parameter int WPM = 8,
    parameter int MFS = 4,
    parameter int WW  = $clog2(WPM),
    parameter int MW  = $clog2(MFS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [WW-1:0] w,
    output logic [MW-1:0] m,
    output logic          last_word,
    output logic          last_mf
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w <= '0;
            m <= '0;
        end else if (clr) begin
            w <= '0;
            m <= '0;
        end else if (adv) begin
            if (w == WW'(WPM - 1)) begin
                w <= '0;
                m <= (m == MW'(MFS - 1)) ? '0 : m + 1'b1;
            end else begin
                w <= w + 1'b1;
            end
        end
    end

    assign last_word = (w == WW'(WPM - 1));
    assign last_mf   = (m == MW'(MFS - 1));

    // R8: the word index never leaves the multiframe
    a_r8_word_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, w} < (WW + 1)'(WPM)));

    // R8: after a clear the position restarts at the first word
    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (w == '0 && m == '0));

endmodule

// File: rtl/jrx_ilas_check.sv
module jrx_ilas_check
    import jrx_pkg::*;
#(
    parameter int WPM = 8,
    parameter int WW  = $clog2(WPM),
    parameter int MW  = 2
) (
    input  logic [31:0]   data,
    input  logic [3:0]    ctl,
    input  logic [3:0]    cerr,
    input  logic [3:0]    derr,
    input  logic [WW-1:0] w,
    input  logic [MW-1:0] m,
    output logic          ok
);

    logic [3:0] oct_ok;

    for (genvar o = 0; o < 4; o++) begin : g_oct
        logic       need_ctl;
        logic [7:0] code;

        always_comb begin
            need_ctl = 1'b0;
            code     = 8'h00;
            if (o == 0 && w == '0) begin
                need_ctl = 1'b1;
                code     = CH_MFBEG;
            end
            if (o == 1 && w == '0 && m == MW'(1)) begin
                need_ctl = 1'b1;
                code     = CH_CFGMK;
            end
            if (o == 3 && w == WW'(WPM - 1)) begin
                need_ctl = 1'b1;
                code     = CH_MFEND;
            end
        end

        assign oct_ok[o] = need_ctl ? (ctl[o] && data[8*o +: 8] == code) : !ctl[o];
    end

    assign ok = (&oct_ok) && !(|cerr) && !(|derr);

endmodule

// File: rtl/jrx_cfg_store.sv
module jrx_cfg_store (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [1:0]   wlo,
    input  logic [31:0]  data,
    output logic [127:0] cfg_flat
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_flat <= '0;
        end else if (we) begin
            for (int o = 0; o < 4; o++) begin
                if ({wlo, 2'(o)} >= 4'd2) begin
                    cfg_flat[{wlo, 2'(o), 3'b000} - 7'd16 +: 8] <= data[8*o +: 8];
                end
            end
        end
    end

    // R6: captured parameters change only on a capture cycle
    a_r6_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_flat));

endmodule

// File: rtl/jrx_lane_sync.sv
module jrx_lane_sync
    import jrx_pkg::*;
#(
    parameter int FRAME_OCTETS   = 2,
    parameter int MF_FRAMES      = 16,
    parameter int ILAS_MFS       = 4,
    parameter int CGS_MIN_OCTETS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lane_valid,
    input  logic [31:0] lane_data,
    input  logic [3:0]  lane_ctl,
    input  logic [3:0]  lane_cerr,
    input  logic [3:0]  lane_derr,
    output logic        sync_n,
    output logic        lane_aligned,
    output logic [3:0]  somf,
    output logic        link_irq,
    output logic        user_valid,
    output logic [31:0] user_data,
    output logic [31:0] cfg_word0,
    output logic [31:0] cfg_word1,
    output logic [31:0] cfg_word2,
    output logic [31:0] cfg_word3
);

    localparam int MF_OCTETS = FRAME_OCTETS * MF_FRAMES;
    localparam int WPM       = MF_OCTETS / 4;
    localparam int WW        = $clog2(WPM);
    localparam int MW        = $clog2(ILAS_MFS);
    localparam int CGS_WORDS = (CGS_MIN_OCTETS + 3) / 4;
    localparam int CW        = $clog2(CGS_WORDS + 1);

    lsync_state_t   state_q, state_d;
    logic [CW-1:0]  cgs_cnt_q, cgs_cnt_d;
    logic           irq_q, irq_d;
    logic           any_err, kword, chk_ok;
    logic           pos_clr, pos_adv, last_word, last_mf, cfg_we;
    logic [WW-1:0]  w;
    logic [MW-1:0]  m;
    logic [127:0]   cfg_flat;

    assign any_err = |(lane_cerr | lane_derr);

    always_comb begin
        kword = (&lane_ctl) && !any_err;
        for (int o = 0; o < 4; o++) begin
            if (lane_data[8*o +: 8] != CH_COMMA) kword = 1'b0;
        end
    end

    jrx_ilas_check #(.WPM(WPM), .WW(WW), .MW(MW)) u_check (
        .data (lane_data),
        .ctl  (lane_ctl),
        .cerr (lane_cerr),
        .derr (lane_derr),
        .w    (w),
        .m    (m),
        .ok   (chk_ok)
    );

    // next-state logic
    always_comb begin
        state_d   = state_q;
        cgs_cnt_d = cgs_cnt_q;
        irq_d     = 1'b0;
        if (lane_valid) begin
            unique case (state_q)
                S_CGS: begin
                    if (any_err) begin
                        cgs_cnt_d = '0;
                        irq_d     = 1'b1;
                    end else if (kword) begin
                        if (cgs_cnt_q == CW'(CGS_WORDS - 1)) begin
                            state_d   = S_SYNCED;   // T_CGS_DONE
                            cgs_cnt_d = '0;
                        end else begin
                            cgs_cnt_d = cgs_cnt_q + 1'b1;
                        end
                    end else begin
                        cgs_cnt_d = '0;
                    end
                end
                S_SYNCED: begin
                    if (!kword) begin
                        if (chk_ok) begin
                            state_d = S_ILAS;       // T_ILAS_START
                        end else begin
                            state_d = S_CGS;        // T_ILAS_ABORT
                            irq_d   = 1'b1;
                        end
                    end
                end
                S_ILAS: begin
                    if (!chk_ok) begin
                        state_d = S_CGS;            // T_ILAS_ABORT
                        irq_d   = 1'b1;
                    end else if (last_word && last_mf) begin
                        state_d = S_DATA;           // T_ALIGNED
                    end
                end
                S_DATA: begin
                    if (any_err) irq_d = 1'b1;
                end
                default: state_d = S_CGS;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_CGS;
            cgs_cnt_q <= '0;
            irq_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            cgs_cnt_q <= cgs_cnt_d;
            irq_q     <= irq_d;
        end
    end

    assign pos_clr = (state_d == S_CGS) || (state_d == S_SYNCED);
    assign pos_adv = lane_valid && ((state_d == S_ILAS) || (state_d == S_DATA));

    jrx_ilas_pos #(.WPM(WPM), .MFS(ILAS_MFS), .WW(WW), .MW(MW)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pos_clr),
        .adv       (pos_adv),
        .w         (w),
        .m         (m),
        .last_word (last_word),
        .last_mf   (last_mf)
    );

    assign cfg_we = lane_valid && (state_q == S_ILAS) && chk_ok
                    && (m == MW'(1)) && (int'(w) < 4);

    jrx_cfg_store u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wlo      (w[1:0]),
        .data     (lane_data),
        .cfg_flat (cfg_flat)
    );

    // outputs
    always_comb begin
        sync_n       = (state_q != S_CGS);
        lane_aligned = (state_q == S_DATA);
        user_valid   = lane_aligned && lane_valid;
        user_data    = lane_data;
        somf         = {3'b000, user_valid && (w == '0)};
        link_irq     = irq_q;
        cfg_word0    = cfg_flat[31:0];
        cfg_word1    = cfg_flat[63:32];
        cfg_word2    = cfg_flat[95:64];
        cfg_word3    = cfg_flat[127:96];
    end

    // R2: sync is released only by a clean comma word
    a_r2_release_on_comma: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> $past(lane_valid && kword));

    // R3: an error during code group sync pulses the interrupt and keeps sync low
    a_r3_cgs_error_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && lane_valid && any_err) |=> (link_irq && !sync_n));

    // R5: an illegal alignment word drops the link back to sync request
    a_r5_ilas_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ILAS && lane_valid && !chk_ok) |=> (!sync_n && link_irq && !lane_aligned));

    // R7: alignment never coexists with a sync request
    a_r7_aligned_synced: assert property (@(posedge clk) disable iff (!rst_n)
        lane_aligned |-> sync_n);

    // R8: marker only in lane position 0 and only on user words
    a_r8_somf_position: assert property (@(posedge clk) disable iff (!rst_n)
        (somf != 4'b0000) |-> (user_valid && somf == 4'b0001));

    // R9: data-phase errors keep alignment
    a_r9_data_err_keeps_align: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_aligned && lane_valid && any_err) |=> (lane_aligned && link_irq));

    // R10: idle cycles change nothing
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_valid |=> ($stable(sync_n) && $stable(lane_aligned) && !link_irq && $stable(cfg_word1)));

endmodule

// File: tb/sim_jrx_lane_sync.sv
module sim_jrx_lane_sync;

    localparam int WPM = 8;
    localparam int MFS = 4;
    localparam int NIL = WPM * MFS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lane_valid = 1'b0;
    logic [31:0] lane_data = '0;
    logic [3:0]  lane_ctl = '0;
    logic [3:0]  lane_cerr = '0;
    logic [3:0]  lane_derr = '0;
    logic        sync_n, lane_aligned, link_irq, user_valid;
    logic [3:0]  somf;
    logic [31:0] user_data, cfg_word0, cfg_word1, cfg_word2, cfg_word3;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    int   dcnt    = 0;
    logic [3:0]  pre_somf;
    logic        pre_uv;
    logic [31:0] pre_ud;
    logic [7:0]  cfgb [14];

    always #2.5 clk = ~clk;

    jrx_lane_sync u0 (
        .clk(clk), .rst_n(rst_n), .lane_valid(lane_valid), .lane_data(lane_data),
        .lane_ctl(lane_ctl), .lane_cerr(lane_cerr), .lane_derr(lane_derr),
        .sync_n(sync_n), .lane_aligned(lane_aligned), .somf(somf), .link_irq(link_irq),
        .user_valid(user_valid), .user_data(user_data),
        .cfg_word0(cfg_word0), .cfg_word1(cfg_word1), .cfg_word2(cfg_word2), .cfg_word3(cfg_word3)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] d, input logic [3:0] c,
                        input logic [3:0] ce, input logic [3:0] de);
        @(negedge clk);
        lane_valid = v; lane_data = d; lane_ctl = c; lane_cerr = ce; lane_derr = de;
        #1;
        pre_somf = somf; pre_uv = user_valid; pre_ud = user_data;
        @(posedge clk);
        #1;
    endtask

    task automatic send_k(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 32'hBCBCBCBC, 4'hF, 4'h0, 4'h0);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; lane_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    function automatic logic [3:0] ictl(input int m, input int w);
        logic [3:0] c = 4'h0;
        if (w == 0) c[0] = 1'b1;
        if (w == 0 && m == 1) c[1] = 1'b1;
        if (w == WPM - 1) c[3] = 1'b1;
        return c;
    endfunction

    function automatic logic [31:0] idat(input int m, input int w);
        logic [31:0] d;
        for (int o = 0; o < 4; o++) begin
            int p = w * 4 + o;
            logic [7:0] b = 8'((m * WPM * 4 + p) * 3 + 1);
            if (w == 0 && o == 0) b = 8'h1C;
            else if (w == 0 && o == 1 && m == 1) b = 8'h9C;
            else if (w == WPM - 1 && o == 3) b = 8'h7C;
            else if (m == 1 && p >= 2 && p < 16) b = cfgb[p - 2];
            d[8*o +: 8] = b;
        end
        return d;
    endfunction

    function automatic logic [31:0] exp_cfg(input int r);
        logic [31:0] v = '0;
        for (int b = 0; b < 4; b++)
            if (4 * r + b < 14) v[8*b +: 8] = cfgb[4 * r + b];
        return v;
    endfunction

    task automatic rand_cfg;
        for (int j = 0; j < 14; j++) cfgb[j] = 8'($urandom);
    endtask

    task automatic run_ilas(input int bad_idx, input int bad_oct, input bit bad_is_err);
        for (int idx = 0; idx < NIL; idx++) begin
            int m = idx / WPM;
            int w = idx % WPM;
            logic [3:0] c = ictl(m, w);
            logic [3:0] de = 4'h0;
            if (idx == bad_idx) begin
                if (bad_is_err) de[bad_oct] = 1'b1;
                else c[bad_oct] = ~c[bad_oct];
            end
            step(1'b1, idat(m, w), c, 4'h0, de);
            if (idx == bad_idx) begin
                chk("R5 abort sync_n", sync_n, 0);
                chk("R5 abort irq", link_irq, 1);
                chk("R7 abort no align", lane_aligned, 0);
                return;
            end else if (idx < NIL - 1) begin
                chk("R7 not yet aligned", lane_aligned, 0);
            end else begin
                chk("R7 aligned after last end char", lane_aligned, 1);
                chk("R5 no irq on legal sequence", link_irq, 0);
            end
        end
        dcnt = 0;
    endtask

    task automatic check_cfg;
        chk("R6 cfg_word0", cfg_word0, exp_cfg(0));
        chk("R6 cfg_word1", cfg_word1, exp_cfg(1));
        chk("R6 cfg_word2", cfg_word2, exp_cfg(2));
        chk("R6 cfg_word3", cfg_word3, exp_cfg(3));
    endtask

    task automatic run_data(input int n);
        int got = 0;
        while (got < n) begin
            logic v = ($urandom % 5) != 0;
            logic [31:0] d = $urandom;
            step(v, d, 4'h0, 4'h0, 4'h0);
            if (v) begin
                chk("R8 somf", pre_somf, (dcnt % WPM == 0) ? 1 : 0);
                chk("R11 user_valid", pre_uv, 1);
                chk("R11 user_data", pre_ud, d);
                chk("R9 no irq clean data", link_irq, 0);
                dcnt++;
                got++;
            end else begin
                chk("R10 idle user_valid", pre_uv, 0);
                chk("R10 idle aligned", lane_aligned, 1);
                chk("R10 idle irq", link_irq, 0);
            end
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        #1;
        // R1 in reset and just after
        chk("R1 sync_n", sync_n, 0);
        chk("R1 aligned", lane_aligned, 0);
        chk("R1 irq", link_irq, 0);
        do_reset;
        chk("R1 cfg_word0", cfg_word0, 0);
        chk("R1 cfg_word3", cfg_word3, 0);

        // R3 error during comma phase
        step(1'b1, 32'hBCBCBCBC, 4'hF, 4'b0100, 4'h0);
        chk("R3 irq on code error", link_irq, 1);
        chk("R3 sync held", sync_n, 0);
        step(1'b1, 32'hBCBCBCBC, 4'hF, 4'h0, 4'b0001);
        chk("R3 irq on disparity error", link_irq, 1);
        // R2 partial comma word
        step(1'b1, 32'h00BCBCBC, 4'b0111, 4'h0, 4'h0);
        chk("R2 partial word keeps sync", sync_n, 0);
        chk("R2 partial word no irq", link_irq, 0);
        send_k(1);
        chk("R2 release after four commas", sync_n, 1);
        // R10 idle cycle
        step(1'b0, 32'h12345678, 4'h0, 4'hF, 4'hF);
        chk("R10 idle sync", sync_n, 1);
        chk("R10 idle no irq", link_irq, 0);
        // R4 bad opener
        send_k(2);
        chk("R4 commas hold sync", sync_n, 1);
        step(1'b1, 32'h11223355, 4'h0, 4'h0, 4'h0);
        chk("R4 bad opener drops sync", sync_n, 0);
        chk("R4 bad opener irq", link_irq, 1);

        // full sequence, data phase
        send_k(1);
        chk("R2 resync", sync_n, 1);
        send_k(3);
        rand_cfg();
        run_ilas(-1, 0, 1'b0);
        check_cfg();
        run_data(3 * WPM);
        // R9 corner: error on multiframe start word
        while (dcnt % WPM != 0) begin
            step(1'b1, $urandom, 4'h0, 4'h0, 4'h0);
            dcnt++;
        end
        step(1'b1, 32'hCAFE0001, 4'h0, 4'h0, 4'b1000);
        dcnt++;
        chk("R8 marker on errored start word", pre_somf, 1);
        chk("R9 data error irq", link_irq, 1);
        chk("R9 stays aligned", lane_aligned, 1);
        check_cfg();

        // R7 corner: final end char carries disparity error
        do_reset;
        send_k(1);
        rand_cfg();
        run_ilas(NIL - 1, 3, 1'b1);
        // R5 missing config marker
        send_k(1);
        run_ilas(WPM, 1, 1'b0);

        // random corruption
        for (int it = 0; it < 10; it++) begin
            int bad;
            do_reset;
            send_k(1);
            chk("R2 random resync", sync_n, 1);
            send_k($urandom % 3);
            rand_cfg();
            bad = (($urandom % 3) == 0) ? -1 : int'($urandom % NIL);
            run_ilas(bad, int'($urandom % 4), 1'($urandom % 2));
            if (bad < 0) begin
                check_cfg();
                run_data(2 * WPM);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule